// File: doc/BRIEF.md
# Three-Wire Addressed Register Loader

This block receives configuration words over a three-wire serial port made of a serial clock, a serial data line and an active-low select. While the select is low, each rising edge of the serial clock shifts one data bit into a shift register, most significant bit first. When the select returns high, the captured word is copied into one of two holding registers. The bit that arrived last is the address bit and chooses the target. Leading bits beyond the register length simply fall off, and the number of clock pulses is never checked.

All three serial lines are synchronized into the system clock domain, and their edges are detected there, so the serial clock never clocks a flop. The holding registers come out as named control fields: the synthesizer dividers, the oscillator select and pretune, the transmit filter and compensation controls, the charge-pump current, the demodulator tuning code and the test-mode selection. A one-cycle strobe marks each load of each register. The fields are plain levels, and the strobes are plain pulses. There is no valid/ready handshake, because a holding register always accepts a load and no downstream consumer can stall it.

Top module: `serial_word_loader`

## Requirements
- R1: After reset every output field is zero, and neither load strobe pulses until a frame has been completed.
- R2: While ser_sel_n is low, each rising edge of ser_clk captures ser_dat. Bits enter most significant bit first, and the frame bit received last is the address bit (frame bit 0).
- R3: A frame that ends with address bit 0 loads the second register. Its fields are taken from frame bits [11:7] (demodulator tuning), [6:4] (compensation scale) and [3:1] (test mode). Frame bits above bit 11 are ignored, and the first register is left unchanged.
- R4: A frame that ends with address bit 1 loads the first register. Its fields are taken from frame bits [23:22] (reference ratio), [21:17] (swallow count), [16:15] (main count), [14] (oscillator select), [12] (test high bit), [11] (filter enable), [10] (compensation enable), [9:7] (deviation scale), [6:4] (pretune) and [3:1] (charge-pump code). Frame bit 13 is ignored, and the second register is left unchanged.
- R5: When more than 24 bits arrive in one frame, only the last 24 are kept; the earlier bits are dropped.
- R6: A frame of fewer than 24 bits leaves zeros in the frame positions above the bits that arrived.
- R7: Serial clock edges while ser_sel_n is high have no effect: no strobe and no field change.
- R8: Each completed frame produces exactly one single-cycle strobe, on cfg_w1_stb for address 1 or on cfg_w2_stb for address 0. The strobe rises in the same cycle as the new field values appear, and the two strobes never pulse together.
- R9: cfg_cp_step is the charge-pump code read as a signed step: code 0 gives -4, code 7 gives +3, and every step in between is the code minus 4.
- R10: A frame with no clock pulses loads all zeros into the second register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock (asynchronous) |
| ser_dat | input | 1 | Serial data (asynchronous) |
| ser_sel_n | input | 1 | Active-low frame select (asynchronous) |
| cfg_ref_ratio | output | 2 | Reference divider ratio code |
| cfg_swallow | output | 5 | Swallow counter value |
| cfg_main_div | output | 2 | Main counter code |
| cfg_osc_sel | output | 1 | Oscillator select |
| cfg_test_hi | output | 1 | Test-mode high bit |
| cfg_filt_en | output | 1 | Transmit filter enable |
| cfg_comp_en | output | 1 | Modulation compensation enable |
| cfg_dev_scale | output | 3 | Deviation scale code |
| cfg_pretune | output | 3 | Oscillator pretune code |
| cfg_cp_code | output | 3 | Charge-pump current code |
| cfg_cp_step | output | 4 | Signed charge-pump step |
| cfg_demod_dac | output | 5 | Demodulator tuning code |
| cfg_comp_scale | output | 3 | Compensation scale code |
| cfg_test_mode | output | 3 | Test-mode selection |
| cfg_w1_stb | output | 1 | First register load strobe |
| cfg_w2_stb | output | 1 | Second register load strobe |

## Verification
The assertions assume that the serial lines are slow compared with the system clock. Each level of ser_clk and ser_sel_n must last several system cycles, and ser_dat must settle while ser_clk is low, so that the synchronized data is already stable when the clock edge is seen. The bench holds every serial level for four system cycles and waits eight cycles after a select edge before driving the next clock edge. Under these conditions each frame completion shows up as exactly one detected select rise, and the field registers change only in the cycle that carries a strobe.

// File: rtl/swl_pkg.sv
package swl_pkg;
  localparam int FRAME_BITS   = 24;
  localparam int REF_W        = 2;
  localparam int SWALLOW_W    = 5;
  localparam int MAIN_W       = 2;
  localparam int CODE3_W      = 3;
  localparam int DEMOD_W      = 5;
  localparam int STEP_W       = 4;

  typedef struct packed {
    logic [REF_W-1:0]     ref_ratio;
    logic [SWALLOW_W-1:0] swallow;
    logic [MAIN_W-1:0]    main_div;
    logic                 osc_sel;
    logic                 test_hi;
    logic                 filt_en;
    logic                 comp_en;
    logic [CODE3_W-1:0]   dev_scale;
    logic [CODE3_W-1:0]   pretune;
    logic [CODE3_W-1:0]   cp_code;
  } word1_t;

  typedef struct packed {
    logic [DEMOD_W-1:0] demod_dac;
    logic [CODE3_W-1:0] comp_scale;
    logic [CODE3_W-1:0] test_mode;
  } word2_t;

  function automatic logic signed [STEP_W-1:0] cp_code_to_step(input logic [CODE3_W-1:0] code);
    logic signed [STEP_W-1:0] wide;
    wide = $signed({1'b0, code});
    return wide - STEP_W'(4);
  endfunction
endpackage

// File: rtl/swl_edge_sync.sv
module swl_edge_sync #(
  parameter int          WIDTH     = 3,
  parameter int          STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_line
      logic [STAGES:0] pipe;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= {(STAGES+1){RESET_VAL[i]}};
        else        pipe <= {pipe[STAGES-1:0], async_in[i]};
      end
      assign level[i] = pipe[STAGES-1];
      assign rise[i]  = pipe[STAGES-1] & ~pipe[STAGES];
      assign fall[i]  = ~pipe[STAGES-1] & pipe[STAGES];
    end
  endgenerate
endmodule

// File: rtl/swl_shifter.sv
module swl_shifter #(
  parameter int LEN = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear,
  input  logic           shift,
  input  logic           din,
  output logic [LEN-1:0] sr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr <= '0;
    else if (clear) sr <= '0;
    else if (shift) sr <= {sr[LEN-2:0], din};
  end
endmodule

// File: rtl/swl_word_bank.sv
module swl_word_bank
  import swl_pkg::*;
#(
  parameter int LEN = FRAME_BITS
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [LEN-1:0] sr,
  output word1_t         w1,
  output word2_t         w2,
  output logic           w1_stb,
  output logic           w2_stb
);
  word1_t nxt1;
  word2_t nxt2;
  logic   unused_frame_bits;

  always_comb begin
    nxt1.ref_ratio = sr[23:22];
    nxt1.swallow   = sr[21:17];
    nxt1.main_div  = sr[16:15];
    nxt1.osc_sel   = sr[14];
    nxt1.test_hi   = sr[12];
    nxt1.filt_en   = sr[11];
    nxt1.comp_en   = sr[10];
    nxt1.dev_scale = sr[9:7];
    nxt1.pretune   = sr[6:4];
    nxt1.cp_code   = sr[3:1];
    nxt2.demod_dac  = sr[11:7];
    nxt2.comp_scale = sr[6:4];
    nxt2.test_mode  = sr[3:1];
  end

  assign unused_frame_bits = sr[13];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w1     <= '0;
      w2     <= '0;
      w1_stb <= 1'b0;
      w2_stb <= 1'b0;
    end else begin
      w1_stb <= load & sr[0];
      w2_stb <= load & ~sr[0];
      if (load && sr[0])  w1 <= nxt1;
      if (load && !sr[0]) w2 <= nxt2;
    end
  end
endmodule

// File: rtl/serial_word_loader.sv
module serial_word_loader
  import swl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ser_clk,
  input  logic                      ser_dat,
  input  logic                      ser_sel_n,
  output logic [REF_W-1:0]          cfg_ref_ratio,
  output logic [SWALLOW_W-1:0]      cfg_swallow,
  output logic [MAIN_W-1:0]         cfg_main_div,
  output logic                      cfg_osc_sel,
  output logic                      cfg_test_hi,
  output logic                      cfg_filt_en,
  output logic                      cfg_comp_en,
  output logic [CODE3_W-1:0]        cfg_dev_scale,
  output logic [CODE3_W-1:0]        cfg_pretune,
  output logic [CODE3_W-1:0]        cfg_cp_code,
  output logic signed [STEP_W-1:0]  cfg_cp_step,
  output logic [DEMOD_W-1:0]        cfg_demod_dac,
  output logic [CODE3_W-1:0]        cfg_comp_scale,
  output logic [CODE3_W-1:0]        cfg_test_mode,
  output logic                      cfg_w1_stb,
  output logic                      cfg_w2_stb
);
  localparam int IDX_DAT = 0;
  localparam int IDX_CLK = 1;
  localparam int IDX_SEL = 2;
  localparam int NLINES  = 3;
  localparam logic [NLINES-1:0] IDLE_VAL = 3'b100;

  logic [NLINES-1:0]     lvl, rise_v, fall_v;
  logic [FRAME_BITS-1:0] sr;
  logic                  shift_pulse, frame_start, en_rise;
  logic                  unused_edges;
  word1_t                w1;
  word2_t                w2;

  swl_edge_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES), .RESET_VAL(IDLE_VAL)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({ser_sel_n, ser_clk, ser_dat}),
    .level    (lvl),
    .rise     (rise_v),
    .fall     (fall_v)
  );

  assign shift_pulse  = rise_v[IDX_CLK] & ~lvl[IDX_SEL];
  assign frame_start  = fall_v[IDX_SEL];
  assign en_rise      = rise_v[IDX_SEL];
  assign unused_edges = ^{rise_v[IDX_DAT], fall_v[IDX_DAT], fall_v[IDX_CLK], lvl[IDX_CLK]};

  swl_shifter #(.LEN(FRAME_BITS)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (frame_start),
    .shift (shift_pulse),
    .din   (lvl[IDX_DAT]),
    .sr    (sr)
  );

  swl_word_bank #(.LEN(FRAME_BITS)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (en_rise),
    .sr     (sr),
    .w1     (w1),
    .w2     (w2),
    .w1_stb (cfg_w1_stb),
    .w2_stb (cfg_w2_stb)
  );

  assign cfg_ref_ratio  = w1.ref_ratio;
  assign cfg_swallow    = w1.swallow;
  assign cfg_main_div   = w1.main_div;
  assign cfg_osc_sel    = w1.osc_sel;
  assign cfg_test_hi    = w1.test_hi;
  assign cfg_filt_en    = w1.filt_en;
  assign cfg_comp_en    = w1.comp_en;
  assign cfg_dev_scale  = w1.dev_scale;
  assign cfg_pretune    = w1.pretune;
  assign cfg_cp_code    = w1.cp_code;
  assign cfg_cp_step    = cp_code_to_step(w1.cp_code);
  assign cfg_demod_dac  = w2.demod_dac;
  assign cfg_comp_scale = w2.comp_scale;
  assign cfg_test_mode  = w2.test_mode;
endmodule

// File: rtl/swl_checker.sv
module swl_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        load_evt,
  input logic        w1_stb,
  input logic        w2_stb,
  input logic [21:0] w1_bits,
  input logic [10:0] w2_bits,
  input logic [2:0]  cp_code,
  input logic [3:0]  cp_step
);
  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(w1_stb && w2_stb)) else $error("strobes overlap");
  p_w1_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    w1_stb |=> !w1_stb) else $error("w1 strobe longer than one cycle");
  p_w2_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    w2_stb |=> !w2_stb) else $error("w2 strobe longer than one cycle");
  p_load_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (w1_stb || w2_stb) |-> $past(load_evt)) else $error("strobe without select rise");
  p_w1_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !w1_stb |-> $stable(w1_bits)) else $error("word 1 changed without strobe");
  p_w2_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !w2_stb |-> $stable(w2_bits)) else $error("word 2 changed without strobe");
  p_cp_sign_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cp_step[3] == !cp_code[2]) else $error("charge-pump step sign wrong");
endmodule

bind serial_word_loader swl_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .load_evt(en_rise),
  .w1_stb  (cfg_w1_stb),
  .w2_stb  (cfg_w2_stb),
  .w1_bits ({cfg_ref_ratio, cfg_swallow, cfg_main_div, cfg_osc_sel, cfg_test_hi,
             cfg_filt_en, cfg_comp_en, cfg_dev_scale, cfg_pretune, cfg_cp_code}),
  .w2_bits ({cfg_demod_dac, cfg_comp_scale, cfg_test_mode}),
  .cp_code (cfg_cp_code),
  .cp_step (cfg_cp_step)
);

// File: tb/tb_serial_word_loader.sv
module tb_serial_word_loader;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_BIT   = 4;
  localparam int NVEC       = 9;
  // each entry: {frame length (6 bits), frame bits right-aligned (32 bits)}
  localparam logic [37:0] VECS [NVEC] = '{
    {6'd24, 32'h00B5A3C7},
    {6'd14, 32'h00003AD6},
    {6'd24, 32'h003C5A1F},
    {6'd30, 32'h2ABCDE71},
    {6'd9,  32'h000000A7},
    {6'd14, 32'h00001FFE},
    {6'd0,  32'h00000000},
    {6'd24, 32'h00FFFFFF},
    {6'd24, 32'h00000001}
  };

  logic clk = 0, rst_n = 0, ser_clk = 0, ser_dat = 0, ser_sel_n = 1;
  logic [1:0] ref_ratio; logic [4:0] swallow; logic [1:0] main_div;
  logic osc_sel, test_hi, filt_en, comp_en;
  logic [2:0] dev_scale, pretune, cp_code, comp_scale, test_mode;
  logic signed [3:0] cp_step;
  logic [4:0] demod_dac;
  logic w1_stb, w2_stb;

  int n_chk = 0, n_bad = 0;
  int cnt1 = 0, cnt2 = 0, dbl = 0;
  logic prev1 = 0, prev2 = 0;
  logic [23:0] exp1 = '0;
  logic [11:0] exp2 = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_word_loader dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_sel_n(ser_sel_n),
    .cfg_ref_ratio(ref_ratio), .cfg_swallow(swallow), .cfg_main_div(main_div),
    .cfg_osc_sel(osc_sel), .cfg_test_hi(test_hi), .cfg_filt_en(filt_en), .cfg_comp_en(comp_en),
    .cfg_dev_scale(dev_scale), .cfg_pretune(pretune), .cfg_cp_code(cp_code), .cfg_cp_step(cp_step),
    .cfg_demod_dac(demod_dac), .cfg_comp_scale(comp_scale), .cfg_test_mode(test_mode),
    .cfg_w1_stb(w1_stb), .cfg_w2_stb(w2_stb)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (w1_stb) cnt1++;
      if (w2_stb) cnt2++;
      if ((w1_stb && prev1) || (w2_stb && prev2) || (w1_stb && w2_stb)) dbl++;
      prev1 = w1_stb; prev2 = w2_stb;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input int len, input logic [31:0] bits);
    ser_sel_n = 0;
    wait_cyc(8);
    for (int i = len - 1; i >= 0; i--) begin
      ser_dat = bits[i];
      wait_cyc(HALF_BIT);
      ser_clk = 1;
      wait_cyc(HALF_BIT);
      ser_clk = 0;
    end
    wait_cyc(HALF_BIT);
    ser_sel_n = 1;
    wait_cyc(12);
  endtask

  task automatic check_fields(input string tag);
    chk({tag, " R4 ref_ratio"}, int'(ref_ratio), int'(exp1[23:22]));
    chk({tag, " R4 swallow"},   int'(swallow),   int'(exp1[21:17]));
    chk({tag, " R4 main_div"},  int'(main_div),  int'(exp1[16:15]));
    chk({tag, " R4 osc_sel"},   int'(osc_sel),   int'(exp1[14]));
    chk({tag, " R4 test_hi"},   int'(test_hi),   int'(exp1[12]));
    chk({tag, " R4 filt_en"},   int'(filt_en),   int'(exp1[11]));
    chk({tag, " R4 comp_en"},   int'(comp_en),   int'(exp1[10]));
    chk({tag, " R4 dev_scale"}, int'(dev_scale), int'(exp1[9:7]));
    chk({tag, " R4 pretune"},   int'(pretune),   int'(exp1[6:4]));
    chk({tag, " R4 cp_code"},   int'(cp_code),   int'(exp1[3:1]));
    chk({tag, " R9 cp_step"},   int'(cp_step),   int'(exp1[3:1]) - 4);
    chk({tag, " R3 demod_dac"}, int'(demod_dac), int'(exp2[11:7]));
    chk({tag, " R3 comp_scale"},int'(comp_scale),int'(exp2[6:4]));
    chk({tag, " R3 test_mode"}, int'(test_mode), int'(exp2[3:1]));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    wait_cyc(5);
    rst_n = 1;
    wait_cyc(10);
    // R1: reset state
    check_fields("reset R1");
    chk("R1 no strobe after reset", cnt1 + cnt2, 0);

    // table walk: R2 R5 R6 R8 R10
    for (int v = 0; v < NVEC; v++) begin
      int len, c1, c2;
      logic [31:0] bits;
      logic [23:0] sr;
      len  = int'(VECS[v][37:32]);
      bits = VECS[v][31:0];
      sr   = (len >= 24) ? bits[23:0] : 24'(bits & ((32'd1 << len) - 1));
      c1 = cnt1; c2 = cnt2;
      send_frame(len, bits);
      if (sr[0]) exp1 = sr; else exp2 = sr[11:0];
      check_fields($sformatf("vec%0d R2 R5 R6 R10", v));
      chk($sformatf("vec%0d R8 w1 strobes", v), cnt1 - c1, sr[0] ? 1 : 0);
      chk($sformatf("vec%0d R8 w2 strobes", v), cnt2 - c2, sr[0] ? 0 : 1);
    end
    chk("R8 strobes single and exclusive", dbl, 0);

    // R7: clock pulses with select high
    begin
      int c1, c2;
      c1 = cnt1; c2 = cnt2;
      ser_dat = 1;
      for (int k = 0; k < 6; k++) begin
        wait_cyc(HALF_BIT); ser_clk = 1; wait_cyc(HALF_BIT); ser_clk = 0;
      end
      wait_cyc(12);
      chk("R7 no strobe while deselected", (cnt1 - c1) + (cnt2 - c2), 0);
      check_fields("R7 idle clocks");
    end

    // R9 all charge-pump codes via word-1 frames
    for (int c = 0; c < 8; c++) begin
      logic [31:0] f;
      f = {20'd0, 3'(c), 1'b1};
      send_frame(24, f);
      exp1 = f[23:0];
      chk($sformatf("R9 step code %0d", c), int'(cp_step), c - 4);
    end

    // R10 empty frame after nonzero word 2
    send_frame(14, 32'h00003FFE);
    exp2 = 12'hFFE;
    chk("R3 word2 loaded before empty frame", int'(demod_dac), 31);
    send_frame(0, 32'h0);
    exp2 = '0;
    check_fields("R10 empty frame");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule